// File: doc/BRIEF.md
# DS3 Receive Frame Aligner

This block accepts a serial DS3 line bit stream, one bit per rising edge of the recovered line clock. It finds the multiframe structure of that stream and reports when it is out of frame. Once aligned, it flags each framing bit that arrives wrong. While in frame it also drives timing for the terminal side:

- a pulse on the first bit of each multiframe;
- an active-low marker on every overhead bit;
- the line bits retimed so that they leave on the falling clock edge.

The two X-bits are latched onto their own status outputs. A run-of-zeros monitor raises a loss-of-signal flag.

The multiframe is 4760 bits long. It is built from seven 680-bit subframes, and each subframe holds eight 85-bit groups. The first bit of every group is an overhead bit. Within a subframe the overhead bits are, by group index 0 to 7: X/P/M, F, C, F, C, F, C, F. The F-bits follow the pattern 1, 0, 0, 1. The M-bits in the last three subframes read 0, 1, 0.

To search for alignment, the aligner slips its bit position by one whenever an F-bit is wrong. Whenever an M-bit is wrong, it relabels the subframe. It declares in-frame only after one whole multiframe passes with every F-bit and M-bit correct. It returns to the search when 3 of the last 16 F-bits are in error.

Top module: `ds3_rx_aligner`

## Requirements
- R1: While in frame, `gap_n_o` is low for exactly the overhead bits, which are multiframe bits whose index modulo 85 is 0, so successive low pulses are 85 bits apart. While out of frame, `gap_n_o` stays high.
- R2: While in frame, `frm_o` is high for multiframe bit 0 only. While out of frame, `frm_o` stays low.
- R3: In-frame is declared only after one complete multiframe in which every F-bit and every M-bit is correct. The first in-frame bit is multiframe bit 0. The aligner locks from any starting phase, given that both X-bits of a frame are equal and both P-bits are equal.
- R4: A single wrong F-bit while in frame gives a one-bit-wide high pulse on `fe_o` and leaves the aligner in frame. A correct stream gives no pulse.
- R5: Out-of-frame (`oof_o` = 1) is declared on the F-bit that completes 3 errors within the last 16 F-bits. Two errors within such a window do not cause out-of-frame.
- R6: `fe_o` stays low whenever out-of-frame is declared, including on the F-bit that triggers it.
- R7: While in frame, `x1_o` holds the value of multiframe bit 0 and `x2_o` holds the value of multiframe bit 680.
- R8: `pay_o` carries each line bit. It changes on the falling clock edge that follows the rising edge at which the bit was taken.
- R9: `los_o` rises after 175 consecutive zero bits and falls on the next one bit.
- R10: When the stream is delayed by a few bits while in frame, the aligner leaves frame and then relocks to the new multiframe start.
- R11: During reset: `oof_o` = 1, `fe_o` = 0, `frm_o` = 0, `gap_n_o` = 1, `x1_o` = `x2_o` = 0, `los_o` = 0 and `pay_o` = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Line clock; data is taken on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| rx_data | input | 1 | Serial line data |
| oof_o | output | 1 | High while out of frame |
| fe_o | output | 1 | One-bit pulse for each wrong F-bit while in frame |
| frm_o | output | 1 | Multiframe start pulse |
| gap_n_o | output | 1 | Active-low overhead-bit marker |
| pay_o | output | 1 | Retimed line data, launched on the falling edge |
| x1_o | output | 1 | Latched first X-bit |
| x2_o | output | 1 | Latched second X-bit |
| los_o | output | 1 | Loss of signal after a run of zeros |

## Verification
Every status output except `pay_o` describes the bit taken at the previous rising edge, so it is valid one full cycle after that bit is driven. The bench drives each bit on the falling edge and samples 1 ns after the following rising edge. At that sample point the flags, the frame pulse and the gap refer to the bit just taken.

`pay_o` is due half a cycle later than the other outputs. The bench therefore reads it 1 ns after the falling edge, where it must show the newest bit, and again after the next rising edge, where it must still show that same bit.

An injected error, or the third error within a window, is checked on the sample of the F-bit that carries it. The bench reaches that bit by walking the stream index to the next odd-numbered overhead group.

// File: rtl/ds3_rxa_pkg.sv
package ds3_rxa_pkg;

    localparam int GRP_BITS    = 85;
    localparam int GRPS_PER_SF = 8;
    localparam int SUBFRAMES   = 7;

    localparam int SF_BITS = GRP_BITS * GRPS_PER_SF;
    localparam int MF_BITS = SF_BITS * SUBFRAMES;
    localparam int BIT_W   = $clog2(GRP_BITS);
    localparam int GRP_W   = $clog2(GRPS_PER_SF);
    localparam int SF_W    = $clog2(SUBFRAMES);

    typedef struct packed {
        logic [SF_W-1:0]  sf;
        logic [GRP_W-1:0] grp;
        logic [BIT_W-1:0] bitp;
    } mf_pos_t;

    typedef enum logic [1:0] {OH_PAYLOAD, OH_FBIT, OH_MBIT, OH_OTHER} oh_kind_t;

    typedef enum logic {ST_HUNT, ST_LOCKED} sync_state_t;

    // Which kind of bit sits at a given multiframe position.
    function automatic oh_kind_t classify(mf_pos_t p);
        if (p.bitp != '0)
            return OH_PAYLOAD;
        if (p.grp[0])
            return OH_FBIT;
        if ((p.grp == '0) && (p.sf >= SF_W'(SUBFRAMES - 3)))
            return OH_MBIT;
        return OH_OTHER;
    endfunction

    // F-bit value: 1 in the first and last odd group, 0 in the middle two.
    function automatic logic f_expected(logic [GRP_W-1:0] grp);
        return (grp == GRP_W'(1)) || (grp == GRP_W'(GRPS_PER_SF - 1));
    endfunction

    // M-bit value: 0,1,0 across the last three subframes.
    function automatic logic m_expected(logic [SF_W-1:0] sf);
        return sf == SF_W'(SUBFRAMES - 2);
    endfunction

    function automatic logic [SF_W-1:0] sf_inc(logic [SF_W-1:0] sf);
        return (sf == SF_W'(SUBFRAMES - 1)) ? '0 : sf + SF_W'(1);
    endfunction

endpackage

// File: rtl/ds3_rxa_position.sv
module ds3_rxa_position
    import ds3_rxa_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    hold,
    input  logic    bump_sf,
    output mf_pos_t pos,
    output logic    mf_last
);

    logic grp_end;
    logic sf_end;

    always_comb begin
        grp_end = pos.bitp == BIT_W'(GRP_BITS - 1);
        sf_end  = pos.grp == GRP_W'(GRPS_PER_SF - 1);
        mf_last = grp_end && sf_end && (pos.sf == SF_W'(SUBFRAMES - 1));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pos <= '0;
        end else if (!hold) begin
            if (grp_end) begin
                pos.bitp <= '0;
                if (sf_end) begin
                    pos.grp <= '0;
                    pos.sf  <= sf_inc(pos.sf);
                end else begin
                    pos.grp <= pos.grp + GRP_W'(1);
                end
            end else begin
                pos.bitp <= pos.bitp + BIT_W'(1);
                if (bump_sf)
                    pos.sf <= sf_inc(pos.sf);
            end
        end
    end

endmodule

// File: rtl/ds3_rxa_sync.sv
module ds3_rxa_sync
    import ds3_rxa_pkg::*;
#(
    parameter int ERR_WIN = 16,
    parameter int ERR_THR = 3
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    bit_in,
    input  mf_pos_t pos,
    input  logic    mf_last,
    output logic    locked,
    output logic    f_err,
    output logic    hold,
    output logic    bump_sf,
    output logic    trip
);

    localparam int CNT_W = $clog2(ERR_WIN + 1);

    sync_state_t        state;
    oh_kind_t           kind;
    logic               m_err;
    logic               clean;
    logic [ERR_WIN-1:0] hist;
    logic [ERR_WIN-1:0] hist_nx;
    logic [CNT_W-1:0]   err_cnt;

    always_comb begin
        kind    = classify(pos);
        f_err   = (kind == OH_FBIT) && (bit_in != f_expected(pos.grp));
        m_err   = (kind == OH_MBIT) && (bit_in != m_expected(pos.sf));
        hist_nx = {hist[ERR_WIN-2:0], f_err};
        err_cnt = '0;
        for (int i = 0; i < ERR_WIN; i++)
            err_cnt = err_cnt + CNT_W'(hist_nx[i]);
        locked  = state == ST_LOCKED;
        trip    = locked && (kind == OH_FBIT) && (err_cnt >= CNT_W'(ERR_THR));
        hold    = !locked && f_err;
        bump_sf = !locked && m_err;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_HUNT;
            hist  <= '0;
            clean <= 1'b0;
        end else if (state == ST_HUNT) begin
            if (f_err || m_err) begin
                clean <= 1'b0;
            end else if (mf_last) begin
                if (clean) begin
                    state <= ST_LOCKED;
                    hist  <= '0;
                end
                clean <= 1'b1;
            end
        end else if (kind == OH_FBIT) begin
            if (trip) begin
                state <= ST_HUNT;
                hist  <= '0;
                clean <= 1'b0;
            end else begin
                hist <= hist_nx;
            end
        end
    end

endmodule

// File: rtl/ds3_rxa_los.sv
module ds3_rxa_los #(
    parameter int LOS_ZEROS = 175
) (
    input  logic clk,
    input  logic rst,
    input  logic bit_in,
    output logic los
);

    localparam int ZC_W = $clog2(LOS_ZEROS + 1);

    logic [ZC_W-1:0] zcnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            zcnt <= '0;
            los  <= 1'b0;
        end else if (bit_in) begin
            zcnt <= '0;
            los  <= 1'b0;
        end else if (zcnt == ZC_W'(LOS_ZEROS - 1)) begin
            los <= 1'b1;
        end else begin
            zcnt <= zcnt + ZC_W'(1);
        end
    end

endmodule

// File: rtl/ds3_rx_aligner.sv
module ds3_rx_aligner
    import ds3_rxa_pkg::*;
#(
    parameter int ERR_WIN   = 16,
    parameter int ERR_THR   = 3,
    parameter int LOS_ZEROS = 175
) (
    input  logic clk,
    input  logic rst,
    input  logic rx_data,
    output logic oof_o,
    output logic fe_o,
    output logic frm_o,
    output logic gap_n_o,
    output logic pay_o,
    output logic x1_o,
    output logic x2_o,
    output logic los_o
);

    mf_pos_t pos;
    logic    mf_last;
    logic    locked;
    logic    f_err;
    logic    hold;
    logic    bump_sf;
    logic    trip;
    logic    sync_ok;
    logic    oh_bit;
    logic    pay_q;

    ds3_rxa_position u_pos (
        .clk     (clk),
        .rst     (rst),
        .hold    (hold),
        .bump_sf (bump_sf),
        .pos     (pos),
        .mf_last (mf_last)
    );

    ds3_rxa_sync #(
        .ERR_WIN (ERR_WIN),
        .ERR_THR (ERR_THR)
    ) u_sync (
        .clk     (clk),
        .rst     (rst),
        .bit_in  (rx_data),
        .pos     (pos),
        .mf_last (mf_last),
        .locked  (locked),
        .f_err   (f_err),
        .hold    (hold),
        .bump_sf (bump_sf),
        .trip    (trip)
    );

    ds3_rxa_los #(
        .LOS_ZEROS (LOS_ZEROS)
    ) u_los (
        .clk    (clk),
        .rst    (rst),
        .bit_in (rx_data),
        .los    (los_o)
    );

    always_comb begin
        sync_ok = locked && !trip;
        oh_bit  = pos.bitp == '0;
    end

    // Status outputs describe the bit taken at this edge.
    always_ff @(posedge clk) begin
        if (rst) begin
            oof_o   <= 1'b1;
            fe_o    <= 1'b0;
            frm_o   <= 1'b0;
            gap_n_o <= 1'b1;
            x1_o    <= 1'b0;
            x2_o    <= 1'b0;
            pay_q   <= 1'b0;
        end else begin
            oof_o   <= !sync_ok;
            fe_o    <= sync_ok && f_err;
            frm_o   <= sync_ok && (pos == '0);
            gap_n_o <= !(sync_ok && oh_bit);
            pay_q   <= rx_data;
            if (sync_ok && oh_bit && (pos.grp == '0)) begin
                if (pos.sf == SF_W'(0))
                    x1_o <= rx_data;
                if (pos.sf == SF_W'(1))
                    x2_o <= rx_data;
            end
        end
    end

    // Payload leaves on the falling edge.
    always_ff @(negedge clk) begin
        if (rst)
            pay_o <= 1'b0;
        else
            pay_o <= pay_q;
    end

endmodule

// File: rtl/ds3_rx_aligner_chk.sv
module ds3_rx_aligner_chk
    import ds3_rxa_pkg::*;
(
    input logic clk,
    input logic rst,
    input logic rx_data,
    input logic oof_o,
    input logic fe_o,
    input logic frm_o,
    input logic gap_n_o,
    input logic los_o
);

    logic [BIT_W-1:0] gcnt;
    logic             gseen;

    always_ff @(posedge clk) begin
        if (rst || oof_o) begin
            gcnt  <= '0;
            gseen <= 1'b0;
        end else if (!gap_n_o) begin
            gcnt  <= '0;
            gseen <= 1'b1;
        end else if (gcnt != '1) begin
            gcnt <= gcnt + BIT_W'(1);
        end
    end

    p_gap_spacing_r1: assert property (@(posedge clk) disable iff (rst)
        (!gap_n_o && gseen) |-> (gcnt == BIT_W'(GRP_BITS - 1)));

    p_oof_quiet_r1: assert property (@(posedge clk) disable iff (rst)
        oof_o |-> (gap_n_o && !frm_o));

    p_frm_on_overhead_r2: assert property (@(posedge clk) disable iff (rst)
        frm_o |-> !gap_n_o);

    p_frm_single_r2: assert property (@(posedge clk) disable iff (rst)
        frm_o |=> !frm_o);

    p_fe_single_r4: assert property (@(posedge clk) disable iff (rst)
        fe_o |=> !fe_o);

    p_fe_low_oof_r6: assert property (@(posedge clk) disable iff (rst)
        fe_o |-> !oof_o);

    p_los_rise_r9: assert property (@(posedge clk) disable iff (rst)
        $rose(los_o) |-> !$past(rx_data));

    p_los_fall_r9: assert property (@(posedge clk) disable iff (rst)
        $fell(los_o) |-> $past(rx_data));

endmodule

bind ds3_rx_aligner ds3_rx_aligner_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .rx_data (rx_data),
    .oof_o   (oof_o),
    .fe_o    (fe_o),
    .frm_o   (frm_o),
    .gap_n_o (gap_n_o),
    .los_o   (los_o)
);

// File: tb/tb_ds3_rx_aligner.sv
module tb_ds3_rx_aligner;
    import ds3_rxa_pkg::*;

    localparam int LOCK_LIMIT = 6 * MF_BITS;
    localparam int NROWS      = 4;
    // Row: {start index[12:0], X value, P value, C value}
    localparam logic [15:0] ROWS [NROWS] = '{
        {13'd675,  3'b100},
        {13'd2037, 3'b111},
        {13'd4750, 3'b001},
        {13'd2720, 3'b110}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic rx_data = 1'b0;
    logic oof_o, fe_o, frm_o, gap_n_o, pay_o, x1_o, x2_o, los_o;

    always #5 clk = ~clk;

    ds3_rx_aligner dut (
        .clk     (clk),
        .rst     (rst),
        .rx_data (rx_data),
        .oof_o   (oof_o),
        .fe_o    (fe_o),
        .frm_o   (frm_o),
        .gap_n_o (gap_n_o),
        .pay_o   (pay_o),
        .x1_o    (x1_o),
        .x2_o    (x2_o),
        .los_o   (los_o)
    );

    int   n_tests = 0;
    int   n_fail  = 0;
    int   cur     = 0;
    logic xv, pv, cv;
    logic last_bit, prev_bit, pay_neg;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic logic gen(int idx, logic x, logic p, logic c);
        int i, sf, r, g, b;
        logic [31:0] h;
        i  = idx % MF_BITS;
        sf = i / SF_BITS;
        r  = i % SF_BITS;
        g  = r / GRP_BITS;
        b  = r % GRP_BITS;
        if (b != 0) begin
            h = 32'(i) * 32'h9E3779B1;
            h = h ^ (h >> 15);
            h = h * 32'h85EBCA6B;
            return h[20];
        end
        if (g % 2 == 1) return (g == 1) || (g == 7);
        if (g == 0) begin
            if (sf < 2) return x;
            if (sf < 4) return p;
            return sf == 5;
        end
        return c;
    endfunction

    task automatic drive(input logic b);
        @(negedge clk);
        rx_data = b;
        #1;
        pay_neg  = pay_o;
        prev_bit = last_bit;
        last_bit = b;
        @(posedge clk);
        #1;
    endtask

    task automatic tick(input logic flip);
        drive(gen(cur, xv, pv, cv) ^ flip);
        cur++;
    endtask

    task automatic to_next_f(input logic flip);
        while (!((cur % GRP_BITS == 0) && (((cur % SF_BITS) / GRP_BITS) % 2 == 1)))
            tick(1'b0);
        tick(flip);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        rx_data = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        rst = 1'b0;
        last_bit = 1'b0;
    endtask

    task automatic wait_lock(output int waited);
        waited = 0;
        while (oof_o && waited < LOCK_LIMIT) begin
            tick(1'b0);
            waited++;
        end
    endtask

    initial begin
        repeat (199000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        int waited, cnt;
        do_reset();
        // R11: reset values
        check({oof_o, fe_o, frm_o, gap_n_o, x1_o, x2_o, los_o, pay_o} == 8'b1001_0000,
              "R11", "reset outputs",
              int'({oof_o, fe_o, frm_o, gap_n_o, x1_o, x2_o, los_o, pay_o}), 8'b1001_0000);

        for (int r = 0; r < NROWS; r++) begin
            int ef, eg, eo, ep;
            do_reset();
            cur = int'(ROWS[r][15:3]);
            {xv, pv, cv} = ROWS[r][2:0];
            wait_lock(waited);
            check(!oof_o, "R3", "lock reached", int'(oof_o), 0);
            check(waited >= MF_BITS, "R3", "no lock before a clean multiframe", waited, MF_BITS);
            check(frm_o && ((cur - 1) % MF_BITS == 0), "R3", "lock at multiframe bit 0",
                  (cur - 1) % MF_BITS, 0);
            ef = 0; eg = 0; eo = 0; ep = 0;
            for (int k = 0; k < MF_BITS + SF_BITS; k++) begin
                int i;
                tick(1'b0);
                i = (cur - 1) % MF_BITS;
                if (frm_o != (i == 0)) ef++;
                if (gap_n_o != (i % GRP_BITS != 0)) eg++;
                if (fe_o || oof_o) eo++;
                if ((pay_o != prev_bit) || (pay_neg != prev_bit)) ep++;
            end
            check(ef == 0, "R2", "frame pulse positions", ef, 0);
            check(eg == 0, "R1", "gap positions", eg, 0);
            check(eo == 0, "R4", "no error pulse on clean stream", eo, 0);
            check(ep == 0, "R8", "payload retimed on falling edge", ep, 0);
            check(x1_o == xv, "R7", "first X-bit", int'(x1_o), int'(xv));
            check(x2_o == xv, "R7", "second X-bit", int'(x2_o), int'(xv));
        end

        // R4: single F error gives one pulse, stays in frame
        to_next_f(1'b1);
        check(fe_o && !oof_o, "R4", "fe on single F error", int'({fe_o, oof_o}), 2);
        tick(1'b0);
        check(!fe_o, "R4", "fe one bit wide", int'(fe_o), 0);

        // R5: two errors in a window are tolerated
        repeat (ERR_SPAN) tick(1'b0);
        to_next_f(1'b1);
        to_next_f(1'b1);
        repeat (20) tick(1'b0);
        check(!oof_o, "R5", "two F errors keep frame", int'(oof_o), 0);

        // R5/R6: third error declares out-of-frame with fe low
        repeat (ERR_SPAN) tick(1'b0);
        to_next_f(1'b1);
        to_next_f(1'b1);
        check(fe_o && !oof_o, "R5", "second error still in frame", int'({fe_o, oof_o}), 2);
        to_next_f(1'b1);
        check(oof_o, "R5", "third error declares oof", int'(oof_o), 1);
        check(!fe_o, "R6", "fe low on the tripping bit", int'(fe_o), 0);
        cnt = 0;
        waited = 0;
        while (oof_o && waited < LOCK_LIMIT) begin
            tick(1'b0);
            if (fe_o && oof_o) cnt++;
            waited++;
        end
        check(cnt == 0, "R6", "fe low while out of frame", cnt, 0);
        check(!oof_o && frm_o && ((cur - 1) % MF_BITS == 0), "R3", "relock after oof",
              (cur - 1) % MF_BITS, 0);

        // R10: stream delayed by two bits
        cur = cur - 2;
        waited = 0;
        while (!oof_o && waited < 2 * MF_BITS) begin
            tick(1'b0);
            waited++;
        end
        check(oof_o, "R10", "shift leads to oof", int'(oof_o), 1);
        wait_lock(waited);
        check(!oof_o && frm_o && ((cur - 1) % MF_BITS == 0), "R10", "relock on shifted stream",
              (cur - 1) % MF_BITS, 0);

        // R9: loss of signal
        do_reset();
        repeat (174) drive(1'b0);
        check(!los_o, "R9", "no los after 174 zeros", int'(los_o), 0);
        drive(1'b0);
        check(los_o, "R9", "los after 175 zeros", int'(los_o), 1);
        drive(1'b1);
        check(!los_o, "R9", "los cleared by a one", int'(los_o), 0);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    localparam int ERR_SPAN = 18 * 2 * GRP_BITS;

endmodule